// File: doc/BRIEF.md
# Memory Overlay Mapper with I/O Port Registers

This block sits beside an 8-bit CPU and turns I/O port writes into memory-mapping control lines for a 64 KB address space. Three port registers hold the control bits: two overlay enables that redirect 16 KB windows to overlay memory, two bank-select lines for the upper and lower banked areas, and the reset and bus-request lines of a sub-processor. An I/O read returns the register contents. On the control port, the read also returns the sub-processor's ready and acknowledge inputs.

The block also gates the row strobe of the base RAM. When an access falls inside an enabled overlay window, the base RAM must not answer, so its strobe is held off. A special mode input turns this gating off. The overlay select itself still works in that mode. The overlay select and the strobe gating are combinational from the address and the registered enables. The block has no data stream, so all pins are plain control and status signals with no valid/ready handshake.

Top module: `ovl_map_top`

## Requirements
- R1: Ports are decoded on `addr[7:0]` only: 0xFD is the bank port, 0xFE is the overlay port and 0xFF is the control port. `addr[15:8]` is ignored, and any other low byte selects no port.
- R2: A port register loads `data_in[1:0]` on the rising clock edge when `io_wr` is high and its port matches. When either condition is false, no register changes.
- R3: While `rst_n` is low, every registered output is low, except `sub_busreq`, which is high.
- R4: Overlay port bit 0 drives `ovl_en1`. While it is set, a memory request to 0x4000–0x7FFF raises `ovl_sel`.
- R5: Overlay port bit 1 drives `ovl_en2`. While it is set, a memory request to 0x8000–0xBFFF raises `ovl_sel`. Addresses outside the enabled windows leave `ovl_sel` low.
- R6: `ram_ras` follows `ras_req`, except that it is forced low when `mem_req` is high and the address lies inside an enabled overlay window. A strobe with `mem_req` low, such as a refresh, is never blocked.
- R7: While `special_mode` is high, `ram_ras` follows `ras_req` even inside enabled overlay windows.
- R8: Bank port bit 0 drives `bank_hi_sel`, which selects the bank for 0xC000–0xFFFF. Bank port bit 1 drives `bank_lo_sel`, which selects the bank for 0x2000–0x3FFF.
- R9: Control port bit 0 drives `sub_rst` and bit 1 drives `sub_busreq`. A read of the control port returns, from bit 0 upward, `sub_rdy`, `sub_ack`, `sub_rst` and `sub_busreq`, with the upper bits zero.
- R10: `data_out_en` is high only while `io_rd` is high and a port matches, and `data_out` is zero whenever `data_out_en` is low. A read of the bank or overlay port returns that register in bits 1:0.
- R11: A new overlay enable affects `ovl_sel` and `ram_ras` on the first memory access after the clock edge that wrote it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | CPU address bus |
| data_in | input | 8 | CPU write data |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| mem_req | input | 1 | Memory access in progress |
| ras_req | input | 1 | Base RAM row strobe request from the timing logic |
| special_mode | input | 1 | When high, disables strobe gating |
| sub_rdy | input | 1 | Sub-processor ready |
| sub_ack | input | 1 | Sub-processor acknowledge |
| data_out | output | 8 | I/O read data |
| data_out_en | output | 1 | Read data drive enable (bus released when low) |
| ovl_en1 | output | 1 | Overlay enable, window 0x4000–0x7FFF |
| ovl_en2 | output | 1 | Overlay enable, window 0x8000–0xBFFF |
| bank_hi_sel | output | 1 | Bank select for 0xC000–0xFFFF |
| bank_lo_sel | output | 1 | Bank select for 0x2000–0x3FFF |
| sub_rst | output | 1 | Sub-processor reset |
| sub_busreq | output | 1 | Bus request to the sub-processor |
| ovl_sel | output | 1 | Current access goes to overlay memory |
| ram_ras | output | 1 | Gated base RAM row strobe |

## Verification
The assertions assume that `io_wr` stays low while `rst_n` is low. They also assume that the address, strobes and mode are steady around each rising edge, as they are in a CPU bus cycle. The bench changes every input only on the falling clock edge and keeps `io_wr` low through both resets. It samples the combinational outputs one nanosecond after driving them, and samples register outputs on the falling edge that follows the write edge.

// File: rtl/ovl_map_pkg.sv
package ovl_map_pkg;
  localparam int NUM_PORTS = 3;
  localparam int CTRL_W    = 2;
  localparam int NUM_WIN   = 2;

  // Port slot indices (slot order fixes the register array layout)
  localparam int SLOT_BANK = 0;
  localparam int SLOT_OVL  = 1;
  localparam int SLOT_SUB  = 2;

  // Bit positions inside each control register
  localparam int BIT_BANK_HI = 0;
  localparam int BIT_BANK_LO = 1;
  localparam int BIT_OVL1    = 0;
  localparam int BIT_OVL2    = 1;
  localparam int BIT_SUB_RST = 0;
  localparam int BIT_SUB_BRQ = 1;

  // Reset images: only the bus-request line idles high
  localparam logic [CTRL_W-1:0] RST_BANK = 2'b00;
  localparam logic [CTRL_W-1:0] RST_OVL  = 2'b00;
  localparam logic [CTRL_W-1:0] RST_SUB  = 2'b10;
endpackage

// File: rtl/ovl_io_decode.sv
module ovl_io_decode #(
  parameter int NUM_PORTS = 3,
  parameter int IO_AW     = 8,
  parameter logic [NUM_PORTS*IO_AW-1:0] PORT_MAP = 24'hFFFEFD
) (
  input  logic [IO_AW-1:0]     io_addr,
  output logic [NUM_PORTS-1:0] port_hit
);
  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_cmp
    assign port_hit[g] = (io_addr == PORT_MAP[g*IO_AW +: IO_AW]);
  end
endmodule

// File: rtl/ovl_port_reg.sv
module ovl_port_reg #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST_VAL;
    else if (we) q <= wdata;
  end

  // R2: an enabled write lands on the next edge
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q == $past(wdata)));
  // R2: without a write the register holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
  // R3: coming out of reset the register shows its reset image
  a_r3_reset_image: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (q == RST_VAL));
endmodule

// File: rtl/ovl_window.sv
module ovl_window #(
  parameter int AW = 16,
  parameter logic [AW-1:0] LO = 16'h4000,
  parameter logic [AW-1:0] HI = 16'h7FFF
) (
  input  logic [AW-1:0] addr,
  input  logic          mem_req,
  input  logic          en,
  output logic          hit
);
  assign hit = mem_req && en && (addr >= LO) && (addr <= HI);
endmodule

// File: rtl/ovl_map_top.sv
module ovl_map_top #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int IO_ADDR_W = 8,
  parameter logic [IO_ADDR_W-1:0] PORT_BANK = 8'hFD,
  parameter logic [IO_ADDR_W-1:0] PORT_OVL  = 8'hFE,
  parameter logic [IO_ADDR_W-1:0] PORT_SUB  = 8'hFF,
  parameter logic [ADDR_W-1:0] WIN1_LO = 16'h4000,
  parameter logic [ADDR_W-1:0] WIN1_HI = 16'h7FFF,
  parameter logic [ADDR_W-1:0] WIN2_LO = 16'h8000,
  parameter logic [ADDR_W-1:0] WIN2_HI = 16'hBFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_in,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic              mem_req,
  input  logic              ras_req,
  input  logic              special_mode,
  input  logic              sub_rdy,
  input  logic              sub_ack,
  output logic [DATA_W-1:0] data_out,
  output logic              data_out_en,
  output logic              ovl_en1,
  output logic              ovl_en2,
  output logic              bank_hi_sel,
  output logic              bank_lo_sel,
  output logic              sub_rst,
  output logic              sub_busreq,
  output logic              ovl_sel,
  output logic              ram_ras
);
  import ovl_map_pkg::*;

  localparam int NP = NUM_PORTS;
  localparam int CW = CTRL_W;
  localparam int NW = NUM_WIN;
  localparam logic [NP*IO_ADDR_W-1:0] PORT_MAP = {PORT_SUB, PORT_OVL, PORT_BANK};
  localparam logic [NP*CW-1:0]        RST_MAP  = {RST_SUB, RST_OVL, RST_BANK};
  localparam logic [NW*ADDR_W-1:0]    WIN_LO   = {WIN2_LO, WIN1_LO};
  localparam logic [NW*ADDR_W-1:0]    WIN_HI   = {WIN2_HI, WIN1_HI};

  // ---------------- port decode ----------------
  logic [NP-1:0] port_hit;
  ovl_io_decode #(.NUM_PORTS(NP), .IO_AW(IO_ADDR_W), .PORT_MAP(PORT_MAP)) u_dec (
    .io_addr  (addr[IO_ADDR_W-1:0]),
    .port_hit (port_hit)
  );

  // ---------------- control registers ----------------
  logic [CW-1:0] reg_q [NP];
  logic          unused_data;
  assign unused_data = ^data_in[DATA_W-1:CW];

  for (genvar g = 0; g < NP; g++) begin : g_reg
    ovl_port_reg #(.W(CW), .RST_VAL(RST_MAP[g*CW +: CW])) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (io_wr && port_hit[g]),
      .wdata (data_in[CW-1:0]),
      .q     (reg_q[g])
    );
  end

  assign bank_hi_sel = reg_q[SLOT_BANK][BIT_BANK_HI];
  assign bank_lo_sel = reg_q[SLOT_BANK][BIT_BANK_LO];
  assign ovl_en1     = reg_q[SLOT_OVL][BIT_OVL1];
  assign ovl_en2     = reg_q[SLOT_OVL][BIT_OVL2];
  assign sub_rst     = reg_q[SLOT_SUB][BIT_SUB_RST];
  assign sub_busreq  = reg_q[SLOT_SUB][BIT_SUB_BRQ];

  // ---------------- overlay windows and strobe gate ----------------
  logic [NW-1:0] win_en;
  logic [NW-1:0] win_hit;
  assign win_en = {ovl_en2, ovl_en1};

  for (genvar w = 0; w < NW; w++) begin : g_win
    ovl_window #(.AW(ADDR_W), .LO(WIN_LO[w*ADDR_W +: ADDR_W]),
                 .HI(WIN_HI[w*ADDR_W +: ADDR_W])) u_win (
      .addr    (addr),
      .mem_req (mem_req),
      .en      (win_en[w]),
      .hit     (win_hit[w])
    );
  end

  assign ovl_sel = |win_hit;
  assign ram_ras = ras_req && !(ovl_sel && !special_mode);

  // ---------------- read-back ----------------
  logic [DATA_W-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    if (port_hit[SLOT_BANK]) rd_word[CW-1:0] = reg_q[SLOT_BANK];
    if (port_hit[SLOT_OVL])  rd_word[CW-1:0] = reg_q[SLOT_OVL];
    if (port_hit[SLOT_SUB])  rd_word[3:0]    = {sub_busreq, sub_rst, sub_ack, sub_rdy};
  end

  assign data_out_en = io_rd && (|port_hit);
  assign data_out    = data_out_en ? rd_word : '0;

  // ---------------- assertions ----------------
  // R4: overlay 1 redirects its window
  a_r4_win1_select: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && ovl_en1 && addr[15:14] == 2'b01) |-> ovl_sel);
  // R5: overlay 2 redirects its window
  a_r5_win2_select: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && ovl_en2 && addr[15:14] == 2'b10) |-> ovl_sel);
  // R5: the top quarter is never overlaid
  a_r5_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[15:14] == 2'b11) |-> !ovl_sel);
  // R6: overlaid normal access never strobes base RAM
  a_r6_ras_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_sel && !special_mode) |-> !ram_ras);
  // R6: strobe without a memory request passes
  a_r6_refresh_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req && ras_req) |-> ram_ras);
  // R7: special mode lets the strobe through
  a_r7_mode_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (special_mode && ras_req) |-> ram_ras);
  // R10: bus released unless reading
  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> (!data_out_en && data_out == '0));
  // R11: overlay written on the previous edge acts at once
  a_r11_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(io_wr && port_hit[SLOT_OVL] && data_in[0]) &&
     mem_req && addr[15:14] == 2'b01) |-> ovl_sel);
endmodule

// File: tb/test_ovl_map_top.sv
module test_ovl_map_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data_in = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0, mem_req = 1'b0, ras_req = 1'b0;
  logic        special_mode = 1'b0, sub_rdy = 1'b0, sub_ack = 1'b0;
  logic [7:0]  data_out;
  logic        data_out_en, ovl_en1, ovl_en2, bank_hi_sel, bank_lo_sel;
  logic        sub_rst, sub_busreq, ovl_sel, ram_ras;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ovl_map_top i_ovl_map_top (
    .clk, .rst_n, .addr, .data_in, .io_wr, .io_rd, .mem_req, .ras_req,
    .special_mode, .sub_rdy, .sub_ack, .data_out, .data_out_en,
    .ovl_en1, .ovl_en2, .bank_hi_sel, .bank_lo_sel, .sub_rst, .sub_busreq,
    .ovl_sel, .ram_ras
  );

  function automatic logic [8:0] outs();
    return {3'b000, sub_busreq, sub_rst, bank_lo_sel, bank_hi_sel, ovl_en2, ovl_en1};
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // op: 0 = I/O write then check registered outputs {busreq,rst,bank_lo,bank_hi,ovl2,ovl1}
  //     1 = memory access, check {ovl_sel, ram_ras}; ctl = {mem_req, ras_req, special_mode}
  //     2 = I/O read, data[1:0] = {sub_ack, sub_rdy}, check {data_out_en, data_out}
  localparam int NV = 23;
  localparam logic [37:0] TBL [NV] = '{
    {2'd0, 16'h00FE, 8'h01, 3'b000, 9'h021}, // R2 R4 enable overlay 1
    {2'd1, 16'h4000, 8'h00, 3'b110, 9'h002}, // R4 R6 window low edge
    {2'd1, 16'h7FFF, 8'h00, 3'b110, 9'h002}, // R4 R6 window high edge
    {2'd1, 16'h3FFF, 8'h00, 3'b110, 9'h001}, // R5 just below window
    {2'd1, 16'h8000, 8'h00, 3'b110, 9'h001}, // R5 overlay 2 still off
    {2'd1, 16'h5000, 8'h00, 3'b111, 9'h003}, // R7 special mode passes strobe
    {2'd1, 16'h5000, 8'h00, 3'b010, 9'h001}, // R6 refresh strobe not blocked
    {2'd0, 16'h12FE, 8'h03, 3'b000, 9'h023}, // R1 upper byte ignored
    {2'd1, 16'hBFFF, 8'h00, 3'b110, 9'h002}, // R5 window 2 high edge
    {2'd1, 16'hC000, 8'h00, 3'b110, 9'h001}, // R5 above window 2
    {2'd0, 16'h00FD, 8'h03, 3'b000, 9'h02F}, // R8 both bank selects
    {2'd0, 16'h00FC, 8'hFF, 3'b000, 9'h02F}, // R1 unmapped port no effect
    {2'd0, 16'h00FF, 8'h01, 3'b000, 9'h01F}, // R9 reset on, bus request off
    {2'd2, 16'h00FF, 8'h01, 3'b000, 9'h105}, // R9 R10 status read, ready
    {2'd2, 16'h00FF, 8'h02, 3'b000, 9'h106}, // R9 R10 status read, ack
    {2'd2, 16'h00FE, 8'h00, 3'b000, 9'h103}, // R10 overlay readback
    {2'd2, 16'h00FD, 8'h00, 3'b000, 9'h103}, // R10 bank readback
    {2'd2, 16'h00FC, 8'h00, 3'b000, 9'h000}, // R10 unmapped read released
    {2'd2, 16'h33FF, 8'h03, 3'b000, 9'h107}, // R1 R9 upper byte ignored on read
    {2'd0, 16'h00FE, 8'h00, 3'b000, 9'h01C}, // R4 R5 overlays off
    {2'd1, 16'h4000, 8'h00, 3'b110, 9'h001}, // R11 takes effect at once
    {2'd1, 16'h8000, 8'h00, 3'b110, 9'h001}, // R11 window 2 released
    {2'd0, 16'h00FF, 8'h02, 3'b000, 9'h02C}  // R9 bus request back on
  };

  task automatic run_vec(input logic [37:0] v, input int idx);
    logic [1:0]  op = v[37:36];
    logic [8:0]  exp = v[8:0];
    string       tag;
    tag = $sformatf("vector %0d (R1-R11 table)", idx);
    @(negedge clk);
    addr = v[35:20];
    if (op == 2'd0) begin
      data_in = v[19:12];
      io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
      check(tag, outs(), exp);
    end else if (op == 2'd1) begin
      {mem_req, ras_req, special_mode} = v[11:9];
      #1;
      check(tag, {7'b0, ovl_sel, ram_ras}, exp);
      {mem_req, ras_req, special_mode} = 3'b000;
    end else begin
      {sub_ack, sub_rdy} = v[13:12];
      io_rd = 1'b1;
      #1;
      check(tag, {data_out_en, data_out}, exp);
      io_rd = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    // R3: reset state
    #1;
    check("R3 reset outputs", outs(), 9'h020);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3 after release", outs(), 9'h020);

    for (int i = 0; i < NV; i++) run_vec(TBL[i], i);

    // R2: matching address without write strobe changes nothing
    @(negedge clk);
    addr = 16'h00FE; data_in = 8'h03;
    @(negedge clk);
    check("R2 no strobe no load", outs(), 9'h02C);

    // R10: matching port without read strobe leaves bus released
    #1;
    check("R10 no read strobe", {data_out_en, data_out}, 9'h000);

    // R6: overlay on, strobe request low keeps ram_ras low
    io_wr = 1'b1; data_in = 8'h02;
    @(negedge clk);
    io_wr = 1'b0; addr = 16'h9000; mem_req = 1'b1; ras_req = 1'b0;
    #1;
    check("R5 sel without strobe", {7'b0, ovl_sel, ram_ras}, 9'h002);
    mem_req = 1'b0;

    // R3: reset in mid-run restores the reset image
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R3 mid-run reset", outs(), 9'h020);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule